// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This execution unit takes two 128-bit vector operands and produces one 128-bit result. A lane-size control splits each operand into eight 16-bit, four 32-bit or two 64-bit elements. Elements sit in consecutive bit fields, with lane 0 in the least significant bits.

An operation-mode control picks one of three operations:
- packed add over every lane;
- scalar add on lane 0 only;
- alternating subtract/add across the lanes.

Arithmetic is integer and wraps within each lane. There is no vector-length setting: an operation covers either one element or all of them.

An address that comes with the operands is checked for 16-byte alignment. The result, the flags and a valid bit are registered one clock after a valid input.

Top module: `simd_addsub_unit`

## Requirements
- R1: `out_valid` rises on the clock edge after an edge that samples `in_valid` high, and falls after an edge that samples it low. A synchronous active-high `rst` clears `out_valid`.
- R2: `lane_sel` encodes the lane width: 2'b00 gives 16-bit lanes, 2'b01 gives 32-bit lanes and 2'b10 gives 64-bit lanes. Lane i occupies bits [i*W +: W].
- R3: With `op_mode` 2'b00 (packed add), every result lane equals A lane plus B lane modulo 2^W. No carry crosses a lane boundary.
- R4: With `op_mode` 2'b01 (scalar add), result lane 0 equals A lane 0 plus B lane 0 modulo 2^W. Every other lane equals the matching lane of A.
- R5: With `op_mode` 2'b10 (alternating), even-indexed lanes compute A minus B and odd-indexed lanes compute A plus B, each modulo 2^W, for every lane width.
- R6: If `lane_sel` is 2'b11 or `op_mode` is 2'b11, `illegal` is 1 and `result` is zero. Otherwise `illegal` is 0.
- R7: `addr_aligned` is 1 exactly when the four least significant bits of `addr` are zero, that is, when the address is a multiple of 16 bytes.
- R8: `result`, `illegal` and `addr_aligned` keep their values on any edge that samples `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid |
| lane_sel | input | 2 | Lane width select (R2) |
| op_mode | input | 2 | Operation select (R3 to R6) |
| opnd_a | input | 128 | Vector operand A |
| opnd_b | input | 128 | Vector operand B |
| addr | input | 32 | Address accompanying the operands |
| out_valid | output | 1 | Registered result is valid |
| result | output | 128 | Registered vector result |
| illegal | output | 1 | Reserved encoding was used |
| addr_aligned | output | 1 | Address is a multiple of 16 bytes |

## Verification
The bench tries each mode at each lane width with operands of all ones plus one. The carries this produces show whether a lane boundary leaks: a carry that crosses a lane breaks R3.

Alternating mode uses values whose difference goes negative. That separates the subtracting even lanes from the adding odd lanes, and an even/odd swap gives a different result. Scalar mode uses distinct patterns in A and B, so an upper lane that took B or a sum is told apart from a true pass-through of A.

Reserved encodings, addresses with each low bit set, and idle gaps between inputs cover the flag and hold behaviour. Random operands then fill in the rest of the input space.

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit #(
  parameter int DATA_W    = 128,
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        op_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [ADDR_W-1:0] addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal,
  output logic              addr_aligned
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  logic md_scalar, md_alt, bad;
  assign md_scalar = (op_mode == 2'b01);
  assign md_alt    = (op_mode == 2'b10);
  assign bad       = (lane_sel == 2'b11) || (op_mode == 2'b11);

  for (genvar k = 0; k < 3; k++) begin : g_sz
    localparam int W = 16 << k;
    localparam int N = DATA_W / W;
    logic [DATA_W-1:0] r;
    for (genvar j = 0; j < N; j++) begin : g_ln
      logic [W-1:0] a_s, b_s;
      assign a_s = opnd_a[j*W +: W];
      assign b_s = opnd_b[j*W +: W];
      assign r[j*W +: W] = (md_scalar && j != 0) ? a_s :
                           (md_alt && (j % 2 == 0)) ? a_s - b_s : a_s + b_s;
    end
  end

  logic [DATA_W-1:0] nxt;
  always_comb begin
    case (lane_sel)
      2'b00:   nxt = g_sz[0].r;
      2'b01:   nxt = g_sz[1].r;
      2'b10:   nxt = g_sz[2].r;
      default: nxt = '0;
    endcase
    if (bad) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    if (in_valid) begin
      result       <= nxt;
      illegal      <= bad;
      addr_aligned <= (addr[OFS_W-1:0] == '0);
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0));
  p_scalar_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && md_scalar && !bad) |=> (result[DATA_W-1:64] == $past(opnd_a[DATA_W-1:64])));
  p_misalign_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && addr[OFS_W-1:0] != '0) |=> !addr_aligned);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_valid) |=> $stable(result));
endmodule

// File: tb/tb_simd_addsub_unit.sv
module tb_simd_addsub_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   lane_sel = '0, op_mode = '0;
  logic [127:0] opnd_a = '0, opnd_b = '0;
  logic [31:0]  addr = '0;
  logic         out_valid, illegal, addr_aligned;
  logic [127:0] result;

  simd_addsub_unit dut (.clk(clk), .rst(rst), .in_valid(in_valid), .lane_sel(lane_sel),
    .op_mode(op_mode), .opnd_a(opnd_a), .opnd_b(opnd_b), .addr(addr),
    .out_valid(out_valid), .result(result), .illegal(illegal), .addr_aligned(addr_aligned));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic         e_ov = 1'b0, e_ill = 1'b0, e_al = 1'b0, have = 1'b0;
  logic [127:0] e_res = '0;
  string        e_tag = "R1";

  function automatic logic [127:0] model(input logic [127:0] a, b,
                                         input logic [1:0] ls, md);
    int w, n;
    logic [127:0] m, o, x, y, z;
    if (ls == 2'b11 || md == 2'b11) return '0;
    w = 16 << ls;
    n = 128 / w;
    m = (128'h1 << w) - 1;
    o = '0;
    for (int j = 0; j < n; j++) begin
      x = (a >> (j * w)) & m;
      y = (b >> (j * w)) & m;
      if (md == 2'b01 && j > 0)      z = x;
      else if (md == 2'b10 && j % 2 == 0) z = (x - y) & m;
      else                           z = (x + y) & m;
      o = o | (z << (j * w));
    end
    return o;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) e_ov = 1'b0;
    else e_ov = in_valid;
    if (in_valid) begin
      have  = 1'b1;
      e_res = model(opnd_a, opnd_b, lane_sel, op_mode);
      e_ill = (lane_sel == 2'b11 || op_mode == 2'b11);
      e_al  = (addr[3:0] == 4'h0);
      e_tag = e_ill ? "R6" : op_mode == 2'b00 ? "R3/R2" : op_mode == 2'b01 ? "R4/R2" : "R5/R2";
    end else if (!rst) e_tag = "R8";
  end

  task automatic compare();
    n_cmp++;
    if (out_valid !== e_ov) begin
      n_bad++;
      $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, e_ov);
    end
    if (have) begin
      n_cmp++;
      if (result !== e_res || illegal !== e_ill) begin
        n_bad++;
        $display("FAIL %s result act=%h/%0b exp=%h/%0b", e_tag, result, illegal, e_res, e_ill);
      end
      n_cmp++;
      if (addr_aligned !== e_al) begin
        n_bad++;
        $display("FAIL R7 addr_aligned act=%0b exp=%0b", addr_aligned, e_al);
      end
    end
  endtask

  task automatic issue(input logic [1:0] ls, md, input logic [127:0] a, b, input logic [31:0] ad);
    @(negedge clk);
    compare();
    in_valid = 1'b1; lane_sel = ls; op_mode = md; opnd_a = a; opnd_b = b; addr = ad;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      in_valid = 1'b0; opnd_a = ~opnd_a; lane_sel = 2'b11; addr = addr + 1;
    end
  endtask

  initial begin
    logic [127:0] ones, one, hi, lo;
    ones = {128{1'b1}};
    one  = 128'h1;
    hi   = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    lo   = 128'h0000_0005_0000_0003_0000_0009_0000_0001;
    repeat (3) begin @(negedge clk); compare(); end
    rst = 1'b0;
    for (int ls = 0; ls < 3; ls++)
      for (int md = 0; md < 3; md++) begin
        issue(ls[1:0], md[1:0], ones, one | (one << 48) | (one << 96), 32'h100);
        issue(ls[1:0], md[1:0], lo, hi, 32'h0);
        issue(ls[1:0], md[1:0], hi, lo, 32'h7);
      end
    issue(2'b11, 2'b00, hi, lo, 32'h10);
    issue(2'b00, 2'b11, hi, lo, 32'h11);
    idle(3);
    for (int b = 0; b < 5; b++) issue(2'b01, 2'b10, hi, hi, 32'h20 | (1 << b));
    idle(2);
    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 3) idle(1);
      issue($urandom_range(0, 3), $urandom_range(0, 3),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, $urandom);
      if (i == 200) begin
        @(negedge clk); compare(); rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); compare(); rst = 1'b0;
      end
    end
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule